// File: doc/BRIEF.md
# Idle Wake Controller with Divided-Clock Mode

This block decides when a processor core stops and restarts around an idle instruction. A one-cycle request parks the core by dropping its run enable. In plain idle the core restarts one cycle after an enabled interrupt is seen. In divided idle the block runs a slow internal tick with a period of n core cycles, where n is 16, 32, 64 or 128. A wake is only allowed on a tick boundary, so the interrupt response time grows with n, up to n cycles. An interrupt that arrives between ticks is held until the next tick.

The block also produces the gated enable for the core clock output. That enable follows the inverse of a disable control bit, one cycle late.

Top module: `idle_wake_ctrl`

## Requirements
- R1: While reset is held, run_en is 1, wake_pulse is 0, div_tick is 0 and clkout_en is 1.
- R2: An idle_req sampled while running is accepted, and run_en is 0 from the next cycle on. An idle_req sampled while already idle has no effect.
- R3: In plain idle (div_sel = 0 at acceptance), an irq_pending sampled high makes wake_pulse and run_en both 1 in the next cycle.
- R4: div_code selects n as 00 = 16, 01 = 32, 10 = 64 and 11 = 128. In divided idle, with the first idle cycle counted as index 0, div_tick is 1 exactly in the cycles whose index modulo n equals n-1. div_tick is 0 whenever the core runs.
- R5: In divided idle a wake happens only in the cycle right after a div_tick cycle. The wake comes at most n cycles after the interrupt cycle.
- R6: A one-cycle irq_pending pulse during divided idle is remembered and still causes the wake at the next tick.
- R7: div_code and div_sel are captured when the request is accepted. Changes to them during idle have no effect.
- R8: With no enabled interrupt the block stays idle, and wake_pulse remains 0.
- R9: wake_pulse lasts one cycle, and run_en is 1 in that same cycle.
- R10: clkout_en equals the inverse of clkout_dis as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | One-cycle request to enter idle |
| div_sel | input | 1 | 1 selects divided idle, 0 selects plain idle |
| div_code | input | 2 | Divisor code: 00=16, 01=32, 10=64, 11=128 |
| irq_pending | input | 1 | An enabled interrupt is pending |
| clkout_dis | input | 1 | Suppresses the clock output when 1 |
| run_en | output | 1 | Core may execute |
| div_tick | output | 1 | One-cycle pulse on each divided-clock boundary |
| wake_pulse | output | 1 | One-cycle pulse when idle ends |
| clkout_en | output | 1 | Clock output gate enable |

## Verification
Two events can fall in the same cycle: an interrupt arriving and the tick boundary that closes a divided period. When that happens, the interrupt must be acted on at once instead of being stored for a whole further period. The bench provokes this by raising irq_pending exactly in the cycle whose index is n-1, for every divisor code. It then requires the wake in the very next cycle. A second run places the pulse at index 0 and requires the wake n cycles later. A third run places the pulse one cycle past a tick and requires the wake a full period later. Together these pin down both the single-cycle case and the latched case.

// File: rtl/idle_wake_pkg.sv
package idle_wake_pkg;

  typedef enum logic [1:0] {
    IW_RUN   = 2'd0,
    IW_PLAIN = 2'd1,
    IW_DIV   = 2'd2
  } iw_state_e;

  // period of the divided tick for a given code: 2^(base+code)
  function automatic int unsigned iw_period(input int unsigned base_log2,
                                            input int unsigned code);
    return 32'd1 << (base_log2 + code);
  endfunction

  // counter width needed to hold period-1 for the largest code
  function automatic int unsigned iw_cnt_width(input int unsigned base_log2,
                                               input int unsigned code_w);
    return base_log2 + (32'd1 << code_w) - 1;
  endfunction

endpackage

// File: rtl/iw_tick_gen.sv
module iw_tick_gen
  import idle_wake_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 4,
  parameter int unsigned CODE_W    = 2,
  parameter int unsigned CNT_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int unsigned NCODES = 1 << CODE_W;

  logic [CNT_W-1:0] last_tab [NCODES];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_v;

  for (genvar g = 0; g < NCODES; g++) begin : g_last
    assign last_tab[g] = CNT_W'(iw_period(BASE_LOG2, g) - 1);
  end

  assign last_v = last_tab[code];
  assign tick   = active && (cnt_q == last_v);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!active || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/iw_state_ctrl.sv
module iw_state_ctrl
  import idle_wake_pkg::*;
#(
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_req,
  input  logic              div_sel,
  input  logic [CODE_W-1:0] code_in,
  input  logic              irq,
  input  logic              tick,
  output iw_state_e         state,
  output logic [CODE_W-1:0] code_q,
  output logic              accept,
  output logic              wake_fire,
  output logic              irq_held,
  output logic              wake_q
);
  always_comb begin
    accept    = (state == IW_RUN) && idle_req;
    wake_fire = ((state == IW_PLAIN) && irq) ||
                ((state == IW_DIV) && tick && (irq_held || irq));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IW_RUN;
      code_q   <= '0;
      irq_held <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      wake_q <= wake_fire;
      case (state)
        IW_RUN: begin
          irq_held <= 1'b0;
          if (accept) begin
            state  <= div_sel ? IW_DIV : IW_PLAIN;
            code_q <= code_in;
          end
        end
        IW_PLAIN: begin
          if (irq) state <= IW_RUN;
        end
        IW_DIV: begin
          if (wake_fire) begin
            state    <= IW_RUN;
            irq_held <= 1'b0;
          end else if (irq) begin
            irq_held <= 1'b1;
          end
        end
        default: state <= IW_RUN;
      endcase
    end
  end
endmodule

// File: rtl/iw_clkout_gate.sv
module iw_clkout_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic dis,
  output logic en
);
  always_ff @(posedge clk) begin
    if (!rst_n) en <= 1'b1;
    else        en <= !dis;
  end
endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
  import idle_wake_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 4,
  parameter int unsigned CODE_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_req,
  input  logic              div_sel,
  input  logic [CODE_W-1:0] div_code,
  input  logic              irq_pending,
  input  logic              clkout_dis,
  output logic              run_en,
  output logic              div_tick,
  output logic              wake_pulse,
  output logic              clkout_en
);
  localparam int unsigned CNT_W = iw_cnt_width(BASE_LOG2, CODE_W);

  iw_state_e         state;
  logic [CODE_W-1:0] code_q;
  logic              accept_idle;
  logic              wake_fire;
  logic              irq_held;
  logic              in_plain;
  logic              in_div;
  logic              tick;

  assign in_plain = (state == IW_PLAIN);
  assign in_div   = (state == IW_DIV);

  iw_state_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_req  (idle_req),
    .div_sel   (div_sel),
    .code_in   (div_code),
    .irq       (irq_pending),
    .tick      (tick),
    .state     (state),
    .code_q    (code_q),
    .accept    (accept_idle),
    .wake_fire (wake_fire),
    .irq_held  (irq_held),
    .wake_q    (wake_pulse)
  );

  iw_tick_gen #(.BASE_LOG2(BASE_LOG2), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (in_div),
    .code   (code_q),
    .tick   (tick)
  );

  iw_clkout_gate u_clko (
    .clk   (clk),
    .rst_n (rst_n),
    .dis   (clkout_dis),
    .en    (clkout_en)
  );

  assign run_en   = (state == IW_RUN);
  assign div_tick = tick;
endmodule

// File: rtl/idle_wake_chk.sv
module idle_wake_chk #(
  parameter int unsigned MAX_WAIT = 128
) (
  input logic clk,
  input logic rst_n,
  input logic idle_req,
  input logic irq_pending,
  input logic clkout_dis,
  input logic run_en,
  input logic div_tick,
  input logic wake_pulse,
  input logic clkout_en,
  input logic accept_idle,
  input logic in_plain,
  input logic in_div,
  input logic irq_held
);
  localparam int unsigned WW = $clog2(MAX_WAIT) + 2;
  logic [WW-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) wait_cnt <= '0;
    else if (in_div && (irq_held || irq_pending)) wait_cnt <= wait_cnt + 1'b1;
    else wait_cnt <= '0;
  end

  a_r2_run_drop: assert property (@(posedge clk) disable iff (!rst_n)
    accept_idle |=> !run_en);
  a_r2_idle_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && !run_en && !irq_pending) |=> !run_en);
  a_r3_plain_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (in_plain && irq_pending) |=> (wake_pulse && run_en));
  a_r4_tick_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> !run_en);
  a_r5_wake_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (in_div && !div_tick) |=> !wake_pulse);
  a_r5_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= WW'(MAX_WAIT));
  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_div && irq_pending && !div_tick) |=> irq_held);
  a_r8_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pending && !irq_held) |=> !wake_pulse);
  a_r9_single_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  a_r9_run_with_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> run_en);
  a_r10_clkout: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_dis |=> !clkout_en);
  a_r10_clkout_on: assert property (@(posedge clk) disable iff (!rst_n)
    !clkout_dis |=> clkout_en);
endmodule

bind idle_wake_ctrl idle_wake_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .idle_req    (idle_req),
  .irq_pending (irq_pending),
  .clkout_dis  (clkout_dis),
  .run_en      (run_en),
  .div_tick    (div_tick),
  .wake_pulse  (wake_pulse),
  .clkout_en   (clkout_en),
  .accept_idle (accept_idle),
  .in_plain    (in_plain),
  .in_div      (in_div),
  .irq_held    (irq_held)
);

// File: tb/sim_idle_wake_ctrl.sv
`timescale 1ns/1ps
module sim_idle_wake_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idle_req = 1'b0;
  logic       div_sel = 1'b0;
  logic [1:0] div_code = 2'b00;
  logic       irq_pending = 1'b0;
  logic       clkout_dis = 1'b0;
  logic       run_en, div_tick, wake_pulse, clkout_en;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  idle_wake_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .div_sel(div_sel),
    .div_code(div_code), .irq_pending(irq_pending), .clkout_dis(clkout_dis),
    .run_en(run_en), .div_tick(div_tick), .wake_pulse(wake_pulse),
    .clkout_en(clkout_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // request idle; returns at the negedge of idle index 0
  task automatic enter_idle(input logic sel, input logic [1:0] code);
    @(negedge clk);
    idle_req = 1'b1; div_sel = sel; div_code = code;
    @(negedge clk);
    idle_req = 1'b0;
    chk("R2 run_en low after accept", int'(run_en), 0);
  endtask

  // divided idle; single-cycle irq pulse at index irq_at
  task automatic t_div(input logic [1:0] code, input int irq_at, input bit scramble);
    int n = 16 << code;
    int wake_at = ((irq_at / n) + 1) * n;
    enter_idle(1'b1, code);
    if (scramble) begin
      div_code = ~code; div_sel = 1'b0;   // R7: must not matter
    end
    for (int k = 0; k <= wake_at; k++) begin
      chk(scramble ? "R7 tick with captured code" : "R4 div_tick position",
          int'(div_tick), (k < wake_at && (k % n) == n - 1) ? 1 : 0);
      chk("R5 wake on tick boundary", int'(wake_pulse), (k == wake_at) ? 1 : 0);
      chk("R9 run_en with wake", int'(run_en), (k == wake_at) ? 1 : 0);
      irq_pending = (k == irq_at);
      @(negedge clk);
    end
    irq_pending = 1'b0;
    chk("R9 wake single cycle", int'(wake_pulse), 0);
    chk("R9 run_en stays high", int'(run_en), 1);
  endtask

  task automatic t_plain();
    enter_idle(1'b0, 2'b11);
    @(negedge clk);
    idle_req = 1'b1; div_sel = 1'b1;          // idle request while idle
    @(negedge clk);
    idle_req = 1'b0;
    chk("R2 idle_req while idle", int'(run_en), 0);
    @(negedge clk);
    chk("R8 no wake without irq", int'(wake_pulse), 0);
    chk("R4 no tick in plain idle", int'(div_tick), 0);
    irq_pending = 1'b1;
    @(negedge clk);
    irq_pending = 1'b0;
    chk("R3 plain wake pulse", int'(wake_pulse), 1);
    chk("R3 plain run_en", int'(run_en), 1);
    @(negedge clk);
    chk("R9 wake single cycle", int'(wake_pulse), 0);
    chk("R9 run_en stays high", int'(run_en), 1);
  endtask

  task automatic t_clkout();
    @(negedge clk);
    clkout_dis = 1'b1;
    chk("R10 clkout before edge", int'(clkout_en), 1);
    @(negedge clk);
    chk("R10 clkout suppressed", int'(clkout_en), 0);
    clkout_dis = 1'b0;
    @(negedge clk);
    chk("R10 clkout restored", int'(clkout_en), 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset run_en", int'(run_en), 1);
    chk("R1 reset wake", int'(wake_pulse), 0);
    chk("R1 reset tick", int'(div_tick), 0);
    chk("R1 reset clkout", int'(clkout_en), 1);
    rst_n = 1'b1;
    @(negedge clk);
    t_plain();
    for (int c = 0; c < 4; c++) begin
      int n = 16 << c;
      t_div(2'(c), 0, 1'b0);        // R5 worst latency n
      t_div(2'(c), n - 1, 1'b0);    // R5 irq on tick cycle: wake next cycle
      t_div(2'(c), n / 2, 1'b0);    // R6 latched mid-period pulse
    end
    t_div(2'b00, 16, 1'b0);         // R6/R8 pulse just after a tick: full period more
    t_div(2'b00, 40, 1'b0);         // R8 stays idle through two ticks first
    t_div(2'b00, 3, 1'b1);          // R7 code change ignored
    t_div(2'b01, 5, 1'b1);          // R7 code change ignored
    t_clkout();
    finish_run();
  end
endmodule